// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the scan timing for a 640x480 progressive display refreshed at roughly 60 Hz, all from one clock running at the pixel rate (about 25 MHz). It keeps a horizontal position counter and a vertical line counter. From them it drives the two sync pulses, a flag that marks the visible area, and a pixel/line coordinate pair that starts at zero in the top-left visible pixel, so a downstream picture source can use it directly as an address.

A 6-bit colour word (three channels of 2 bits each) comes in. The block registers it and forces it to black whenever the beam is outside the visible area. Every output leaves a register on the same clock edge, so sync, blanking and colour never skew against each other. The phase lengths are parameters, and so is the sync polarity (active-low unless set otherwise). The same block can therefore drive other modes, or a reduced raster for test.

Top module: `vga_raster_gen`

## Requirements
- R1: While reset is held, the outputs show raster position (0,0): hsync and vsync sit at their asserted level, active is 0, and pix_x, line_y and rgb_out are 0.
- R2: A line lasts 800 clocks. The line starts with sync (96 clocks), then back porch (48), then visible pixels (640), then front porch (16).
- R3: hsync is at its asserted level for exactly the first 96 clocks of each line, which gives one pulse per line.
- R4: A frame lasts 525 lines: sync (2), back porch (33), visible (480), front porch (10). vsync is asserted for the first 2 lines and changes level only on the clock where a new line starts.
- R5: active is 1 only on horizontal positions 144..783 of lines 35..514 (counted from the start of sync). Neither sync is ever asserted while active is 1.
- R6: pix_x equals the horizontal position minus 144 inside the visible columns (0..639) and is 0 elsewhere. line_y equals the line number minus 35 inside the visible lines (0..479) and is 0 elsewhere.
- R7: rgb_in is captured on each clock edge and appears on rgb_out from that edge on. It is forced to 0 when the position entered on that edge is not visible. The channels are red [5:4], green [3:2] and blue [1:0]. All-ones (white) and all-zeros (black) pass through unchanged.
- R8: With SYNC_ACTIVE_HIGH = 0 (the default), both syncs are asserted low. With SYNC_ACTIVE_HIGH = 1, both are asserted high and all other timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| rgb_in | input | 3*CH_W | Colour to show at the next position |
| hsync | output | 1 | Horizontal sync, polarity set by SYNC_ACTIVE_HIGH |
| vsync | output | 1 | Vertical sync, polarity set by SYNC_ACTIVE_HIGH |
| active | output | 1 | High inside the visible area |
| pix_x | output | X_W | Visible column, zero outside it |
| line_y | output | Y_W | Visible line, zero outside it |
| rgb_out | output | 3*CH_W | Blanked colour |

## Verification
Some properties are checked on every cycle. These are the hsync pulse width, the line period measured between pulse starts, the rule that vsync only moves at a line start, the absence of sync during visible time, black outside the visible area, and the step-by-one column count within a visible run. The exact position of each phase in the line and frame, the zero-based coordinate values, and the one-clock capture of rgb_in can only be shown by the bench's scenarios. The bench follows a full-size raster through the start of the visible area, and a reduced raster with active-high syncs through many complete frames.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

   // Phase of one scan axis, in the order it is traversed
   typedef enum logic [1:0] {
      PH_SYNC   = 2'd0,
      PH_BACK   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_FRONT  = 2'd3
   } scan_phase_e;

   localparam int NUM_CHANNELS = 3;

endpackage

// File: rtl/raster_axis.sv
// One wrapping position counter of the raster (horizontal or vertical).
// cnt_nxt is the value the counter takes at the coming edge.
module raster_axis #(
   parameter int TOTAL = 800,
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   output logic [CNT_W-1:0] cnt_nxt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (!step)
         cnt_nxt = cnt_q;
      else if (cnt_q == LAST)
         cnt_nxt = '0;
      else
         cnt_nxt = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/axis_phase_decode.sv
// Maps an axis position to its phase and to a zero-based visible coordinate.
module axis_phase_decode
   import vga_raster_pkg::*;
#(
   parameter int SYNC_LEN = 96,
   parameter int BACK_LEN = 48,
   parameter int ACT_LEN  = 640,
   parameter int CNT_W    = 10,
   parameter int POS_W    = 10
) (
   input  logic [CNT_W-1:0] cnt,
   output scan_phase_e      phase,
   output logic [POS_W-1:0] pos
);

   localparam int ACT_START = SYNC_LEN + BACK_LEN;
   localparam int ACT_END   = ACT_START + ACT_LEN;

   always_comb begin
      if (cnt < CNT_W'(SYNC_LEN))
         phase = PH_SYNC;
      else if (cnt < CNT_W'(ACT_START))
         phase = PH_BACK;
      else if (cnt < CNT_W'(ACT_END))
         phase = PH_ACTIVE;
      else
         phase = PH_FRONT;
   end

   always_comb begin
      if (phase == PH_ACTIVE)
         pos = POS_W'(cnt - CNT_W'(ACT_START));
      else
         pos = '0;
   end

endmodule

// File: rtl/raster_out_stage.sv
// Output register: syncs with polarity, visible flag, coordinates, blanked colour.
module raster_out_stage
   import vga_raster_pkg::*;
#(
   parameter int X_W              = 10,
   parameter int Y_W              = 9,
   parameter int CH_W             = 2,
   parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst,
   input  scan_phase_e                  h_phase,
   input  scan_phase_e                  v_phase,
   input  logic [X_W-1:0]               x_nxt,
   input  logic [Y_W-1:0]               y_nxt,
   input  logic [NUM_CHANNELS*CH_W-1:0] rgb_in,
   output logic                         hsync,
   output logic                         vsync,
   output logic                         active,
   output logic [X_W-1:0]               pix_x,
   output logic [Y_W-1:0]               line_y,
   output logic [NUM_CHANNELS*CH_W-1:0] rgb_out
);

   localparam logic ON_LVL = SYNC_ACTIVE_HIGH ? 1'b1 : 1'b0;

   logic h_in_sync, v_in_sync, act_n;
   logic hs_lvl, vs_lvl;
   logic [NUM_CHANNELS*CH_W-1:0] rgb_gated;

   assign h_in_sync = (h_phase == PH_SYNC);
   assign v_in_sync = (v_phase == PH_SYNC);
   assign act_n     = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);

   generate
      if (SYNC_ACTIVE_HIGH) begin : g_sync_pos
         assign hs_lvl = h_in_sync;
         assign vs_lvl = v_in_sync;
      end else begin : g_sync_neg
         assign hs_lvl = ~h_in_sync;
         assign vs_lvl = ~v_in_sync;
      end
   endgenerate

   generate
      for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_ch
         assign rgb_gated[c*CH_W +: CH_W] = act_n ? rgb_in[c*CH_W +: CH_W] : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hsync   <= ON_LVL;
         vsync   <= ON_LVL;
         active  <= 1'b0;
         pix_x   <= '0;
         line_y  <= '0;
         rgb_out <= '0;
      end else begin
         hsync   <= hs_lvl;
         vsync   <= vs_lvl;
         active  <= act_n;
         pix_x   <= x_nxt;
         line_y  <= y_nxt;
         rgb_out <= rgb_gated;
      end
   end

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
   import vga_raster_pkg::*;
#(
   parameter int H_SYNC           = 96,
   parameter int H_BACK           = 48,
   parameter int H_ACTIVE         = 640,
   parameter int H_FRONT          = 16,
   parameter int V_SYNC           = 2,
   parameter int V_BACK           = 33,
   parameter int V_ACTIVE         = 480,
   parameter int V_FRONT          = 10,
   parameter int CH_W             = 2,
   parameter bit SYNC_ACTIVE_HIGH = 1'b0,
   parameter int X_W              = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1,
   parameter int Y_W              = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [NUM_CHANNELS*CH_W-1:0] rgb_in,
   output logic                         hsync,
   output logic                         vsync,
   output logic                         active,
   output logic [X_W-1:0]               pix_x,
   output logic [Y_W-1:0]               line_y,
   output logic [NUM_CHANNELS*CH_W-1:0] rgb_out
);

   localparam int H_TOTAL = H_SYNC + H_BACK + H_ACTIVE + H_FRONT;
   localparam int V_TOTAL = V_SYNC + V_BACK + V_ACTIVE + V_FRONT;
   localparam int HC_W    = $clog2(H_TOTAL);
   localparam int VC_W    = $clog2(V_TOTAL);

   // Elaboration-time parameter checks
   generate
      if (H_SYNC < 1 || V_SYNC < 1) begin : g_bad_sync
         $error("vga_raster_gen: sync lengths must be at least 1");
      end
      if (H_ACTIVE < 1 || V_ACTIVE < 1) begin : g_bad_act
         $error("vga_raster_gen: visible area must be non-empty");
      end
      if (H_BACK < 0 || H_FRONT < 0 || V_BACK < 0 || V_FRONT < 0) begin : g_bad_porch
         $error("vga_raster_gen: porch lengths must not be negative");
      end
      if (X_W < $clog2(H_ACTIVE) || Y_W < $clog2(V_ACTIVE)) begin : g_bad_pos_w
         $error("vga_raster_gen: coordinate width too small");
      end
      if (CH_W < 1) begin : g_bad_ch
         $error("vga_raster_gen: channel width must be at least 1");
      end
   endgenerate

   logic [HC_W-1:0] h_nxt;
   logic [VC_W-1:0] v_nxt;
   logic            line_wrap;
   scan_phase_e     h_phase, v_phase;
   logic [X_W-1:0]  x_nxt;
   logic [Y_W-1:0]  y_nxt;

   raster_axis #(.TOTAL(H_TOTAL), .CNT_W(HC_W)) h_axis_i (
      .clk     (clk),
      .rst     (rst),
      .step    (1'b1),
      .cnt_nxt (h_nxt)
   );

   // The line counter moves only when the pixel counter wraps to zero
   assign line_wrap = (h_nxt == '0);

   raster_axis #(.TOTAL(V_TOTAL), .CNT_W(VC_W)) v_axis_i (
      .clk     (clk),
      .rst     (rst),
      .step    (line_wrap),
      .cnt_nxt (v_nxt)
   );

   axis_phase_decode #(
      .SYNC_LEN (H_SYNC),
      .BACK_LEN (H_BACK),
      .ACT_LEN  (H_ACTIVE),
      .CNT_W    (HC_W),
      .POS_W    (X_W)
   ) h_dec_i (
      .cnt   (h_nxt),
      .phase (h_phase),
      .pos   (x_nxt)
   );

   axis_phase_decode #(
      .SYNC_LEN (V_SYNC),
      .BACK_LEN (V_BACK),
      .ACT_LEN  (V_ACTIVE),
      .CNT_W    (VC_W),
      .POS_W    (Y_W)
   ) v_dec_i (
      .cnt   (v_nxt),
      .phase (v_phase),
      .pos   (y_nxt)
   );

   raster_out_stage #(
      .X_W              (X_W),
      .Y_W              (Y_W),
      .CH_W             (CH_W),
      .SYNC_ACTIVE_HIGH (SYNC_ACTIVE_HIGH)
   ) out_i (
      .clk     (clk),
      .rst     (rst),
      .h_phase (h_phase),
      .v_phase (v_phase),
      .x_nxt   (x_nxt),
      .y_nxt   (y_nxt),
      .rgb_in  (rgb_in),
      .hsync   (hsync),
      .vsync   (vsync),
      .active  (active),
      .pix_x   (pix_x),
      .line_y  (line_y),
      .rgb_out (rgb_out)
   );

endmodule

// File: rtl/raster_chk.sv
module raster_chk #(
   parameter int H_SYNC           = 96,
   parameter int H_TOTAL          = 800,
   parameter int X_W              = 10,
   parameter int Y_W              = 9,
   parameter int RGB_W            = 6,
   parameter bit SYNC_ACTIVE_HIGH = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             hsync,
   input logic             vsync,
   input logic             active,
   input logic [X_W-1:0]   pix_x,
   input logic [Y_W-1:0]   line_y,
   input logic [RGB_W-1:0] rgb_out
);

   logic hs_on, vs_on, hs_prev, line_start;
   int   hs_len;
   int   ln_cnt;

   assign hs_on      = SYNC_ACTIVE_HIGH ? hsync : ~hsync;
   assign vs_on      = SYNC_ACTIVE_HIGH ? vsync : ~vsync;
   assign line_start = hs_on && !hs_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         hs_prev <= 1'b1;
         hs_len  <= 0;
         ln_cnt  <= 0;
      end else begin
         hs_prev <= hs_on;
         hs_len  <= hs_on ? hs_len + 1 : 0;
         ln_cnt  <= line_start ? 1 : ln_cnt + 1;
      end
   end

   // R3
   hsync_width_chk: assert property (@(posedge clk) disable iff (rst)
      (!hs_on && hs_prev) |-> hs_len == H_SYNC);

   // R2
   line_period_chk: assert property (@(posedge clk) disable iff (rst)
      line_start |-> ln_cnt == H_TOTAL);

   // R4
   vsync_at_line_start_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(vs_on) |-> line_start);

   // R5
   no_sync_in_active_chk: assert property (@(posedge clk) disable iff (rst)
      active |-> (!hs_on && !vs_on));

   // R7
   blank_outside_chk: assert property (@(posedge clk) disable iff (rst)
      !active |-> rgb_out == '0);

   // R6
   x_first_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(active) |-> pix_x == '0);

   // R6
   x_step_chk: assert property (@(posedge clk) disable iff (rst)
      (active && $past(active)) |-> pix_x == $past(pix_x) + X_W'(1));

   // R6
   y_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (active && $past(active)) |-> line_y == $past(line_y));

endmodule

bind vga_raster_gen raster_chk #(
   .H_SYNC           (H_SYNC),
   .H_TOTAL          (H_SYNC + H_BACK + H_ACTIVE + H_FRONT),
   .X_W              (X_W),
   .Y_W              (Y_W),
   .RGB_W            (3 * CH_W),
   .SYNC_ACTIVE_HIGH (SYNC_ACTIVE_HIGH)
) chk_i (
   .clk     (clk),
   .rst     (rst),
   .hsync   (hsync),
   .vsync   (vsync),
   .active  (active),
   .pix_x   (pix_x),
   .line_y  (line_y),
   .rgb_out (rgb_out)
);

// File: tb/vga_raster_gen_tb_top.sv
module vga_raster_gen_tb_top;

   localparam int RUN_CYCLES = 80000;   // 100 full-size lines
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst = 1'b1;
   logic [5:0] rgb_in = 6'd0;

   // Full-size, default polarity
   logic       hs_m, vs_m, act_m;
   logic [9:0] x_m;
   logic [8:0] y_m;
   logic [5:0] rgb_m;

   // Reduced raster, active-high syncs
   logic       hs_s, vs_s, act_s;
   logic [2:0] x_s;
   logic [1:0] y_s;
   logic [5:0] rgb_s;

   vga_raster_gen dut_i (
      .clk(clk), .rst(rst), .rgb_in(rgb_in),
      .hsync(hs_m), .vsync(vs_m), .active(act_m),
      .pix_x(x_m), .line_y(y_m), .rgb_out(rgb_m)
   );

   vga_raster_gen #(
      .H_SYNC(4), .H_BACK(3), .H_ACTIVE(8), .H_FRONT(2),
      .V_SYNC(2), .V_BACK(2), .V_ACTIVE(3), .V_FRONT(1),
      .SYNC_ACTIVE_HIGH(1'b1)
   ) dut_pos_i (
      .clk(clk), .rst(rst), .rgb_in(rgb_in),
      .hsync(hs_s), .vsync(vs_s), .active(act_s),
      .pix_x(x_s), .line_y(y_s), .rgb_out(rgb_s)
   );

   typedef struct {
      logic       hs;
      logic       vs;
      logic       act;
      int         x;
      int         y;
      logic [5:0] rgb;
   } exp_t;

   exp_t q_main[$];
   exp_t q_small[$];

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   task automatic chk(input string req, input string what, input int actual, input int expected);
      n_chk++;
      if (actual != expected) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   function automatic exp_t model(input int h, input int v,
                                  input int hsl, input int hbl, input int hal,
                                  input int vsl, input int vbl, input int val,
                                  input bit pos_pol, input logic [5:0] rgb);
      exp_t e;
      bit in_hs, in_vs, hact, vact;
      in_hs = (h < hsl);
      in_vs = (v < vsl);
      hact  = (h >= hsl + hbl) && (h < hsl + hbl + hal);
      vact  = (v >= vsl + vbl) && (v < vsl + vbl + val);
      e.hs  = pos_pol ? in_hs : !in_hs;
      e.vs  = pos_pol ? in_vs : !in_vs;
      e.act = hact && vact;
      e.x   = hact ? h - (hsl + hbl) : 0;
      e.y   = vact ? v - (vsl + vbl) : 0;
      e.rgb = e.act ? rgb : 6'd0;
      return e;
   endfunction

   // Driver: advances the reference positions, applies a colour, queues expectations
   int hm = 0, vm = 0, hsm = 0, vsm = 0;
   task automatic drive_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         rgb_in = 6'(i * 7 + 3);
         hm++;
         if (hm == 800) begin hm = 0; vm = (vm == 524) ? 0 : vm + 1; end
         hsm++;
         if (hsm == 17) begin hsm = 0; vsm = (vsm == 7) ? 0 : vsm + 1; end
         q_main.push_back(model(hm, vm, 96, 48, 640, 2, 33, 480, 1'b0, rgb_in));
         q_small.push_back(model(hsm, vsm, 4, 3, 8, 2, 2, 3, 1'b1, rgb_in));
         @(negedge clk);
      end
   endtask

   // Monitor: pops expectations and compares, plus period measurements
   int cyc = 0;
   int last_line_m = -1;
   int last_frame_s = -1;
   logic prev_hs_m = 1'b0;
   logic prev_vs_s = 1'b1;

   always @(posedge clk) begin
      #2;
      if (!rst) begin
         cyc++;
         if (q_main.size() > 0) begin
            exp_t e;
            e = q_main.pop_front();
            chk("R3", "main hsync", int'(hs_m), int'(e.hs));
            chk("R4", "main vsync", int'(vs_m), int'(e.vs));
            chk("R5", "main active", int'(act_m), int'(e.act));
            chk("R6", "main pix_x", int'(x_m), e.x);
            chk("R6", "main line_y", int'(y_m), e.y);
            chk("R7", "main rgb_out", int'(rgb_m), int'(e.rgb));
         end
         if (q_small.size() > 0) begin
            exp_t e;
            e = q_small.pop_front();
            chk("R8", "small hsync", int'(hs_s), int'(e.hs));
            chk("R8", "small vsync", int'(vs_s), int'(e.vs));
            chk("R5", "small active", int'(act_s), int'(e.act));
            chk("R6", "small pix_x", int'(x_s), e.x);
            chk("R6", "small line_y", int'(y_s), e.y);
            chk("R7", "small rgb_out", int'(rgb_s), int'(e.rgb));
         end
         // R2: line period between hsync pulse starts (active-low)
         if (!hs_m && prev_hs_m) begin
            if (last_line_m >= 0) chk("R2", "line period", cyc - last_line_m, 800);
            last_line_m = cyc;
         end
         // R4: frame period of the reduced raster, 8 lines of 17 clocks
         if (vs_s && !prev_vs_s) begin
            if (last_frame_s >= 0) chk("R4", "frame period", cyc - last_frame_s, 136);
            last_frame_s = cyc;
         end
         prev_hs_m = hs_m;
         prev_vs_s = vs_s;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state, shown at position (0,0)
      chk("R1", "reset hsync", int'(hs_m), 0);
      chk("R1", "reset vsync", int'(vs_m), 0);
      chk("R1", "reset active", int'(act_m), 0);
      chk("R1", "reset pix_x", int'(x_m), 0);
      chk("R1", "reset line_y", int'(y_m), 0);
      chk("R1", "reset rgb_out", int'(rgb_m), 0);
      // R8: active-high instance asserts its syncs high in reset
      chk("R8", "reset hsync high", int'(hs_s), 1);
      chk("R8", "reset vsync high", int'(vs_s), 1);
      rst = 1'b0;
      drive_cycles(RUN_CYCLES);
      repeat (3) @(negedge clk);
      chk("R2", "line starts seen", int'(last_line_m >= 0), 1);
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired after %0d cycles", WATCHDOG);
         finish_run();
      end
   end

endmodule